// File: doc/BRIEF.md
# Buffered Interrupt Status Controller

This block gathers six interrupt sources and reports them to an external master over one active-low interrupt line. Five sources arrive as single-cycle event pulses. The sixth (FLAGS) is derived inside the block from the not-empty levels of the OUT FIFOs. Each source is gated by an enable byte that the master writes. Accepted events are queued as pending bits and presented one at a time. When the master strobes a read while an interrupt is presented, the block drives a one-hot status byte on its 8-bit data output. That read clears the presented interrupt.

The block also works alongside the command-register read path. Once the master opens a register read request, new interrupts are held back. When the requested data is ready, the block pulls the interrupt line low with READY high, so the master knows the next read returns data rather than the status byte. If an interrupt was already presented when the request opened, that interrupt is served first, with READY low.

The sequencer has four states:
- **IDLE**: nothing is presented.
- **HOLD**: a request is open and its data is not yet ready; the line stays high.
- **PRESENT**: an interrupt is on the line with READY low.
- **DATA**: requested data is on offer; the line is low and READY is high.

Transitions:
- IDLE→DATA when a request is open and its data is ready.
- IDLE→HOLD when a request is open and its data is not ready.
- IDLE→PRESENT when no request is open and an enabled pending bit exists.
- HOLD→DATA when the data becomes ready.
- PRESENT→IDLE on a read strobe.
- DATA→IDLE on a read strobe.

Top module: `irq_status_ctrl`

## Requirements
- R1: The status byte is one-hot, with SETUP at bit 7, EP0BUF at bit 6, FLAGS at bit 5, ENUMOK at bit 2, BUSACTIVITY at bit 1 and READY at bit 0. Bits 4 and 3 are always zero.
- R2: The enable byte uses the same bit positions as the status byte. An event from a disabled source is not recorded, and it never pulls the interrupt line low, even after the source is enabled later.
- R3: An enabled event sampled at clock edge k, with nothing presented and no request open, drives `int_n_o` low after edge k+1. The line then stays low until a read strobe.
- R4: A read strobe while an interrupt is presented (`ready_o` low) drives the status byte on `data_o` in that same cycle. `data_o` is zero at all other times.
- R5: The read clears the presented interrupt. `int_n_o` is high in the next cycle, and any further pending interrupt is presented only after that.
- R6: Pending interrupts are served highest status bit first.
- R7: Repeats of an already-pending event merge into one presentation. An event from the source currently presented is queued again.
- R8: A FLAGS event is raised on each clock where any OUT FIFO not-empty level rises. It is not raised while the level simply stays high.
- R9: After `rdreq_start_i`, no new interrupt is presented until the requested data is read. After `rdreq_done_i`, `int_n_o` goes low with `ready_o` high, and the read that follows returns zero on `data_o`.
- R10: If an interrupt is presented when a request opens, that interrupt's status byte is read first with `ready_o` low. The DATA presentation, with `ready_o` high, follows.
- R11: Reset clears the enable byte and all pending bits, drives `int_n_o` high and `ready_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_setup_i | input | 1 | SETUP event pulse |
| ev_ep0buf_i | input | 1 | EP0BUF event pulse |
| ev_enumok_i | input | 1 | ENUMOK event pulse |
| ev_busact_i | input | 1 | BUSACTIVITY event pulse |
| ev_ready_i | input | 1 | READY event pulse |
| out_nempty_i | input | NUM_OUT_FIFO | OUT FIFO not-empty levels |
| en_we_i | input | 1 | Enable byte write strobe |
| en_wdata_i | input | 8 | Enable byte write data |
| rd_strobe_i | input | 1 | Master read strobe, one cycle |
| rdreq_start_i | input | 1 | Register read request opened |
| rdreq_done_i | input | 1 | Requested register data available |
| int_n_o | output | 1 | Active-low interrupt line |
| ready_o | output | 1 | High when the next read returns requested data |
| data_o | output | 8 | Status byte during a read of a presented interrupt |

## Verification
The assertions assume the following about the inputs:
- `rd_strobe_i` is a single-cycle pulse, given only while `int_n_o` is low.
- A new request opens only when none is outstanding, and `rdreq_done_i` follows `rdreq_start_i` and never comes in the same cycle.
- The enable byte is never rewritten while an interrupt is on the line.

The stimulus keeps to these rules: it reads only after it has seen the line low, it pairs every start with one later done, and it changes the enable byte only while the line is idle. A behavioural model in the bench, built on byte-wide pending masks, predicts the line, READY and the data byte on every clock.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
    localparam int SRC_N      = 6;
    localparam int SRC_READY  = 0;
    localparam int SRC_BUSACT = 1;
    localparam int SRC_ENUMOK = 2;
    localparam int SRC_FLAGS  = 3;
    localparam int SRC_EP0BUF = 4;
    localparam int SRC_SETUP  = 5;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_PRESENT,
        ST_DATA
    } irq_state_e;

    // source vector (index order) to status byte positions
    function automatic logic [7:0] src_to_byte(input logic [SRC_N-1:0] s);
        return {s[SRC_SETUP], s[SRC_EP0BUF], s[SRC_FLAGS], 2'b00,
                s[SRC_ENUMOK], s[SRC_BUSACT], s[SRC_READY]};
    endfunction

    function automatic logic [SRC_N-1:0] byte_to_src(input logic [7:0] b);
        return {b[7], b[6], b[5], b[2], b[1], b[0]};
    endfunction
endpackage

// File: rtl/irq_fifo_rise.sv
module irq_fifo_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    output logic         rise_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = |(lvl_i & ~prev_q);
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    for (genvar gi = 0; gi < N; gi++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          pend_o[gi] <= 1'b0;
            else if (set_i[gi])  pend_o[gi] <= 1'b1;
            else if (clr_i[gi])  pend_o[gi] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N = 6
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    always_comb begin
        logic found;
        found   = 1'b0;
        grant_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i] && !found) begin
                grant_o[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_stat_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         any_i,
    input  logic [N-1:0] grant_i,
    input  logic         rd_i,
    input  logic         start_i,
    input  logic         done_i,
    output logic         take_o,
    output logic         int_n_o,
    output logic         ready_o,
    output logic [7:0]   data_o
);
    irq_state_e   state_q, state_d;
    logic [N-1:0] cur_q;
    logic         req_open_q, data_rdy_q;
    logic         served_data;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_open_q && data_rdy_q) state_d = ST_DATA;
                else if (req_open_q)          state_d = ST_HOLD;
                else if (any_i)               state_d = ST_PRESENT;
            end
            ST_HOLD:    if (data_rdy_q) state_d = ST_DATA;
            ST_PRESENT: if (rd_i)       state_d = ST_IDLE;
            ST_DATA:    if (rd_i)       state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign take_o      = (state_q == ST_IDLE) && !req_open_q && any_i;
    assign served_data = (state_q == ST_DATA) && rd_i;

    // presented source and request tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q      <= '0;
            req_open_q <= 1'b0;
            data_rdy_q <= 1'b0;
        end else begin
            if (take_o)                             cur_q <= grant_i;
            else if (state_q == ST_PRESENT && rd_i) cur_q <= '0;

            if (start_i)          req_open_q <= 1'b1;
            else if (served_data) req_open_q <= 1'b0;

            if (done_i && (req_open_q || start_i)) data_rdy_q <= 1'b1;
            else if (served_data)                  data_rdy_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        int_n_o = 1'b1;
        ready_o = 1'b0;
        data_o  = 8'h00;
        unique case (state_q)
            ST_PRESENT: begin
                int_n_o = 1'b0;
                if (rd_i) data_o = src_to_byte(cur_q);
            end
            ST_DATA: begin
                int_n_o = 1'b0;
                ready_o = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_stat_pkg::*;
#(
    parameter int NUM_OUT_FIFO = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ev_setup_i,
    input  logic                    ev_ep0buf_i,
    input  logic                    ev_enumok_i,
    input  logic                    ev_busact_i,
    input  logic                    ev_ready_i,
    input  logic [NUM_OUT_FIFO-1:0] out_nempty_i,
    input  logic                    en_we_i,
    input  logic [7:0]              en_wdata_i,
    input  logic                    rd_strobe_i,
    input  logic                    rdreq_start_i,
    input  logic                    rdreq_done_i,
    output logic                    int_n_o,
    output logic                    ready_o,
    output logic [7:0]              data_o
);
    logic [SRC_N-1:0] en_q;
    logic [SRC_N-1:0] evt_vec, pend, grant, clr_vec;
    logic             flags_rise, any_avail, take;
    logic [7:0]       en_byte;

    irq_fifo_rise #(.N(NUM_OUT_FIFO)) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (out_nempty_i),
        .rise_o (flags_rise)
    );

    always_comb begin
        evt_vec             = '0;
        evt_vec[SRC_READY]  = ev_ready_i;
        evt_vec[SRC_BUSACT] = ev_busact_i;
        evt_vec[SRC_ENUMOK] = ev_enumok_i;
        evt_vec[SRC_FLAGS]  = flags_rise;
        evt_vec[SRC_EP0BUF] = ev_ep0buf_i;
        evt_vec[SRC_SETUP]  = ev_setup_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_q <= '0;
        else if (en_we_i) en_q <= byte_to_src(en_wdata_i);
    end

    assign en_byte = src_to_byte(en_q);
    assign clr_vec = take ? grant : '0;

    irq_pend_bank #(.N(SRC_N)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (evt_vec & en_q),
        .clr_i  (clr_vec),
        .pend_o (pend)
    );

    irq_prio_pick #(.N(SRC_N)) u_pick (
        .req_i   (pend & en_q),
        .grant_o (grant),
        .any_o   (any_avail)
    );

    irq_seq_fsm #(.N(SRC_N)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_i   (any_avail),
        .grant_i (grant),
        .rd_i    (rd_strobe_i),
        .start_i (rdreq_start_i),
        .done_i  (rdreq_done_i),
        .take_o  (take),
        .int_n_o (int_n_o),
        .ready_o (ready_o),
        .data_o  (data_o)
    );
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_strobe_i,
    input logic       int_n_o,
    input logic       ready_o,
    input logic [7:0] data_o,
    input logic [7:0] en_byte
);
    AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_i && !int_n_o && !ready_o) |-> ($onehot(data_o) && data_o[4:3] == 2'b00)) // R1
        else $error("status byte malformed");

    AST_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe_i && !int_n_o && !ready_o) |-> ((data_o & ~en_byte) == 8'h00)) // R2
        else $error("disabled source presented");

    AST_LINE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n_o && !rd_strobe_i) |=> !int_n_o) // R3
        else $error("line released without read");

    AST_DATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe_i || int_n_o || ready_o) |-> (data_o == 8'h00)) // R4
        else $error("data driven outside status read");

    AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_n_o && rd_strobe_i) |=> int_n_o) // R5
        else $error("no high cycle after read");

    AST_READY_WITH_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !int_n_o) // R9
        else $error("ready without line");
endmodule

bind irq_status_ctrl irq_status_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_strobe_i (rd_strobe_i),
    .int_n_o     (int_n_o),
    .ready_o     (ready_o),
    .data_o      (data_o),
    .en_byte     (en_byte)
);

// File: tb/irq_status_ctrl_test.sv
module irq_status_ctrl_test;
    localparam int NF = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_setup = 0, ev_ep0buf = 0, ev_enumok = 0, ev_busact = 0, ev_ready = 0;
    logic [NF-1:0] nempty = '0;
    logic en_we = 0;
    logic [7:0] en_wdata = 8'h00;
    logic rd = 0, start = 0, done = 0;
    logic int_n, ready;
    logic [7:0] data;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    irq_status_ctrl #(.NUM_OUT_FIFO(NF)) uut (
        .clk(clk), .rst_n(rst_n),
        .ev_setup_i(ev_setup), .ev_ep0buf_i(ev_ep0buf), .ev_enumok_i(ev_enumok),
        .ev_busact_i(ev_busact), .ev_ready_i(ev_ready), .out_nempty_i(nempty),
        .en_we_i(en_we), .en_wdata_i(en_wdata), .rd_strobe_i(rd),
        .rdreq_start_i(start), .rdreq_done_i(done),
        .int_n_o(int_n), .ready_o(ready), .data_o(data)
    );

    // behavioural reference: byte-wide masks, mode number 0 idle 1 hold 2 shown 3 data
    int       m_mode;
    bit [7:0] m_pend, m_en, m_cur;
    bit       m_req, m_rdy;
    bit [NF-1:0] m_prev;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = 0; m_pend = 0; m_en = 0; m_cur = 0;
            m_req = 0; m_rdy = 0; m_prev = '0;
        end else begin
            bit [7:0] ev, avail, pick;
            int nxt;
            ev = 8'h00;
            ev[7] = ev_setup; ev[6] = ev_ep0buf; ev[5] = |(nempty & ~m_prev);
            ev[2] = ev_enumok; ev[1] = ev_busact; ev[0] = ev_ready;
            avail = m_pend & m_en;
            pick = 8'h00;
            for (int b = 7; b >= 0; b--)
                if (avail[b] && pick == 8'h00) pick[b] = 1'b1;
            nxt = m_mode;
            case (m_mode)
                0: begin
                    if (m_req && m_rdy) nxt = 3;
                    else if (m_req) nxt = 1;
                    else if (pick != 8'h00) begin
                        nxt = 2; m_cur = pick; m_pend = m_pend & ~pick;
                    end
                end
                1: if (m_rdy) nxt = 3;
                2: if (rd) begin nxt = 0; m_cur = 0; end
                default: if (rd) begin nxt = 0; m_req = 0; m_rdy = 0; end
            endcase
            m_pend = m_pend | (ev & m_en);
            if (start) m_req = 1;
            if (done && m_req) m_rdy = 1;
            if (en_we) m_en = en_wdata & 8'hE7;
            m_prev = nempty;
            m_mode = nxt;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        logic e_int_n, e_ready;
        logic [7:0] e_data;
        e_int_n = !(m_mode == 2 || m_mode == 3);
        e_ready = (m_mode == 3);
        e_data  = (m_mode == 2 && rd) ? m_cur : 8'h00;
        check(int_n === e_int_n, "R3 model line", int'(int_n), int'(e_int_n));
        check(ready === e_ready, "R9 model ready", int'(ready), int'(e_ready));
        check(data === e_data, "R4 model data", int'(data), int'(e_data));
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic write_en(input logic [7:0] v);
        step(); en_we = 1; en_wdata = v; step(); en_we = 0;
    endtask

    task automatic wait_low(input string req);
        int n;
        n = 0;
        @(negedge clk);
        while (int_n !== 1'b0 && n < 30) begin @(negedge clk); n++; end
        check(int_n === 1'b0, req, int'(int_n), 0);
    endtask

    task automatic stay_high(input int cyc, input string req);
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            check(int_n === 1'b1, req, int'(int_n), 1);
        end
    endtask

    task automatic do_read(output logic [7:0] d, output logic r);
        step(); rd = 1;
        @(negedge clk); d = data; r = ready;
        step(); rd = 0;
    endtask

    initial begin
        logic [7:0] d;
        logic r;
        // R11 reset state
        repeat (3) @(negedge clk);
        check(int_n === 1'b1 && ready === 1'b0, "R11 reset outputs", {int_n, ready}, 2'b10);
        step(); rst_n = 1;
        write_en(8'hFF);

        // R3 latency, R4/R1 read value, R5 gap
        step(); ev_ready = 1; step(); ev_ready = 0;
        @(negedge clk); check(int_n === 1'b1, "R3 still high one edge after", int'(int_n), 1);
        @(negedge clk); check(int_n === 1'b0, "R3 low two edges after", int'(int_n), 0);
        do_read(d, r);
        check(d === 8'h01 && r === 1'b0, "R1 R4 READY status byte", d, 8'h01);
        @(negedge clk); check(int_n === 1'b1, "R5 high after read", int'(int_n), 1);

        // R6 priority order
        step(); ev_busact = 1; ev_enumok = 1; ev_setup = 1; step();
        ev_busact = 0; ev_enumok = 0; ev_setup = 0;
        wait_low("R6 line low");
        do_read(d, r); check(d === 8'h80, "R6 first SETUP", d, 8'h80);
        @(negedge clk); check(int_n === 1'b1, "R5 gap between queued", int'(int_n), 1);
        wait_low("R6 second low");
        do_read(d, r); check(d === 8'h04, "R6 second ENUMOK", d, 8'h04);
        wait_low("R6 third low");
        do_read(d, r); check(d === 8'h02, "R6 third BUSACTIVITY", d, 8'h02);
        stay_high(4, "R6 queue drained");

        // R7 merge and re-queue
        step(); ev_setup = 1; step(); ev_setup = 0;
        wait_low("R7 setup shown");
        step(); ev_busact = 1; step(); ev_busact = 0; step(); ev_busact = 1; ev_setup = 1;
        step(); ev_busact = 0; ev_setup = 0;
        do_read(d, r); check(d === 8'h80, "R7 first", d, 8'h80);
        wait_low("R7 requeued low");
        do_read(d, r); check(d === 8'h80, "R7 setup requeued", d, 8'h80);
        wait_low("R7 merged low");
        do_read(d, r); check(d === 8'h02, "R7 busact once", d, 8'h02);
        stay_high(8, "R7 repeats merged");

        // R2 disabled sources
        write_en(8'h80);
        step(); ev_ready = 1; ev_busact = 1; ev_ep0buf = 1; step();
        ev_ready = 0; ev_busact = 0; ev_ep0buf = 0;
        stay_high(8, "R2 disabled silent");
        write_en(8'hFF);
        stay_high(6, "R2 not recorded while disabled");

        // R8 FLAGS on rising not-empty
        step(); nempty[0] = 1;
        wait_low("R8 flags low");
        do_read(d, r); check(d === 8'h20, "R8 FLAGS byte", d, 8'h20);
        stay_high(8, "R8 no refire while level high");
        step(); nempty[1] = 1;
        wait_low("R8 second fifo rise");
        do_read(d, r); check(d === 8'h20, "R8 FLAGS again", d, 8'h20);
        step(); nempty = '0; step(); nempty[0] = 1;
        wait_low("R8 after fall and rise");
        do_read(d, r); check(d === 8'h20, "R8 FLAGS third", d, 8'h20);

        // R9 held during request
        step(); start = 1; step(); start = 0;
        step(); step(); ev_setup = 1; step(); ev_setup = 0;
        stay_high(6, "R9 held while request open");
        step(); done = 1; step(); done = 0;
        wait_low("R9 data line low");
        check(ready === 1'b1, "R9 ready high with line", int'(ready), 1);
        do_read(d, r); check(d === 8'h00 && r === 1'b1, "R9 data read zero", d, 8'h00);
        wait_low("R9 held event released");
        check(ready === 1'b0, "R9 event ready low", int'(ready), 0);
        do_read(d, r); check(d === 8'h80, "R9 held SETUP", d, 8'h80);

        // R10 pending before request
        step(); ev_enumok = 1; step(); ev_enumok = 0;
        wait_low("R10 interrupt shown");
        step(); start = 1; step(); start = 0; step(); done = 1; step(); done = 0;
        @(negedge clk);
        check(int_n === 1'b0 && ready === 1'b0, "R10 status first ready low", {int_n, ready}, 0);
        do_read(d, r); check(d === 8'h04 && r === 1'b0, "R10 status byte", d, 8'h04);
        wait_low("R10 data follows");
        check(ready === 1'b1, "R10 ready high", int'(ready), 1);
        do_read(d, r); check(d === 8'h00, "R10 data read", d, 8'h00);

        // R11 reset clears pending and enables
        step(); ev_setup = 1; ev_busact = 1; step(); ev_setup = 0; ev_busact = 0;
        wait_low("R11 pre-reset low");
        step(); rst_n = 0;
        @(negedge clk);
        check(int_n === 1'b1 && ready === 1'b0, "R11 reset mid-run", {int_n, ready}, 2'b10);
        step(); rst_n = 1;
        step(); ev_ready = 1; step(); ev_ready = 0;
        stay_high(4, "R11 enables cleared");
        write_en(8'hFF);
        stay_high(8, "R11 pending cleared");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        tests++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule